// File: doc/BRIEF.md
# I2C Target with Banked Register Pointer

This block is an I2C target that gives a bus host byte-wide access to a 32-location register file. The file is split into two banks of 16 bytes. The block oversamples SCL and SDA on a fast system clock and recognises START, repeated START and STOP. It matches a 7-bit device address. It then carries out one of three transaction kinds:
- a write that loads the register pointer and continues with a burst of data bytes;
- a pointer load, followed by a repeated START and a read;
- a read with no pointer phase, which continues from wherever the pointer was left.

The internal pointer steps through its current bank and wraps at the bank's end. It never crosses into the other bank, and it keeps its value from one transaction to the next. On the register side the block presents the pointer as the address, together with a one-cycle write strobe carrying the received byte and a one-cycle read strobe. The read strobe expects the addressed byte on `reg_rdata` in that same cycle. The only drive toward the bus is an open-drain pull-down enable for SDA.

Top module: `i2c_regport`

## Requirements
- R1: After reset `sda_oe` is 0, neither strobe is active, and the pointer (`reg_addr`) is 0x00.
- R2: After a START, the first byte carries the 7-bit device address (parameter `DEV_ADDR`) in bits 7..1 and a direction bit in bit 0, where 0 means write and 1 means read. A matching address is acknowledged by pulling SDA low during the ninth clock.
- R3: When the address does not match, no ACK is given, and the target leaves the bus alone (no SDA drive, no strobes, pointer unchanged) until the next START.
- R4: In a write, the first byte after the address byte loads its low 5 bits into the pointer and is acknowledged.
- R5: Every later write byte produces one `reg_wr` pulse with `reg_addr` equal to the pointer and `reg_wdata` equal to the byte. The byte is acknowledged and the pointer then advances. `reg_wr` and `reg_rd` are never both active.
- R6: When the pointer advances, its low 4 bits increment modulo 16 and bit 4 is left unchanged, so 0x0F is followed by 0x00 and 0x1F by 0x10.
- R7: A write-mode address byte, a pointer byte, a repeated START and a read-mode address byte together return data starting at the pointer just loaded, sent MSB first.
- R8: In a read, each byte is fetched at the pointer, and the pointer advances after every byte sent. A host ACK (0) causes the next byte to be sent.
- R9: After the host answers a byte with NACK (1), the target releases SDA and stays off the bus until STOP or START.
- R10: A read-mode transaction with no pointer phase starts at the pointer left by the previous transaction.
- R11: `sda_oe` changes only while SCL is low, and `reg_rd` pulses only while SCL is low.
- R12: A START or STOP seen at any bit position discards the partial byte. START returns the target to address reception, STOP makes it idle, and the pointer is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| reg_addr | output | 5 | Register pointer; address for both strobes |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_wdata | output | 8 | Byte to write |
| reg_rd | output | 1 | One-cycle read strobe |
| reg_rdata | input | 8 | Byte at `reg_addr`, valid in the `reg_rd` cycle |

## Verification
The assertions rely on the host keeping SCL low for several system clocks after each falling edge, so that the target's SDA updates, which arrive three cycles after the edge, still fall inside the low phase. They also rely on the host changing SDA only while SCL is low, except when it makes a START or STOP. The bench's bus master holds every SCL phase for ten system clocks and moves SDA only in the middle of the low phase. It produces START and STOP with SCL high and SDA released by the target. Random lengths and pointers stay within the 32-location map, and the host drives its own bits only in slots where the target has released SDA.

// File: rtl/i2c_regport.sv
`timescale 1ns/1ps
module i2c_regport #(
  parameter logic [6:0] DEV_ADDR = 7'h32,
  parameter int BANK_BITS = 4,
  localparam int PW = BANK_BITS + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_in,
  input  logic          sda_in,
  output logic          sda_oe,
  output logic [PW-1:0] reg_addr,
  output logic          reg_wr,
  output logic [7:0]    reg_wdata,
  output logic          reg_rd,
  input  logic [7:0]    reg_rdata
);
  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_PTR, S_WDATA, S_RDATA} st_t;

  st_t st;
  logic [1:0] scl_sy, sda_sy;
  logic scl_d, sda_d;
  logic [3:0] bitcnt;
  logic [7:0] sh, tx;
  logic [PW-1:0] ptr;
  logic rw, ack_drv, tx_en;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return {p[PW-1], p[BANK_BITS-1:0] + 1'b1};
  endfunction

  wire scl = scl_sy[1];
  wire sda = sda_sy[1];
  wire scl_rise = scl & ~scl_d;
  wire scl_fall = ~scl & scl_d;
  wire start_c = scl & scl_d & sda_d & ~sda;
  wire stop_c = scl & scl_d & ~sda_d & sda;
  wire byte_end = scl_fall && bitcnt == 4'd8;
  wire ack_end = scl_fall && bitcnt == 4'd9;
  wire matched = sh[7:1] == DEV_ADDR;

  assign sda_oe = ack_drv | (tx_en & ~tx[7]);
  assign reg_addr = ptr;
  assign reg_wdata = sh;
  assign reg_wr = byte_end && st == S_WDATA;
  assign reg_rd = ack_end && ((st == S_ADDR && rw) || st == S_RDATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_in};
      sda_sy <= {sda_sy[0], sda_in};
      scl_d <= scl;
      sda_d <= sda;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      bitcnt <= '0;
      sh <= '0;
      tx <= '0;
      ptr <= '0;
      rw <= 1'b0;
      ack_drv <= 1'b0;
      tx_en <= 1'b0;
    end else if (start_c || stop_c) begin
      st <= start_c ? S_ADDR : S_IDLE;
      bitcnt <= '0;
      ack_drv <= 1'b0;
      tx_en <= 1'b0;
    end else if (st != S_IDLE) begin
      if (scl_rise) begin
        if (bitcnt < 4'd8) begin
          if (st != S_RDATA) sh <= {sh[6:0], sda};
          bitcnt <= bitcnt + 4'd1;
        end else if (st == S_RDATA && bitcnt == 4'd8) begin
          if (sda) st <= S_IDLE;
          else bitcnt <= 4'd9;
        end
      end
      if (byte_end) begin
        if (st == S_RDATA) begin
          tx_en <= 1'b0;
          ptr <= bump(ptr);
        end else if (st == S_ADDR && !matched) begin
          st <= S_IDLE;
        end else begin
          ack_drv <= 1'b1;
          bitcnt <= 4'd9;
          if (st == S_ADDR) rw <= sh[0];
          if (st == S_PTR) ptr <= sh[PW-1:0];
          if (st == S_WDATA) ptr <= bump(ptr);
        end
      end else if (ack_end) begin
        ack_drv <= 1'b0;
        bitcnt <= '0;
        case (st)
          S_ADDR: if (rw) begin
            st <= S_RDATA;
            tx <= reg_rdata;
            tx_en <= 1'b1;
          end else st <= S_PTR;
          S_PTR: st <= S_WDATA;
          S_RDATA: begin
            tx <= reg_rdata;
            tx_en <= 1'b1;
          end
          default: ;
        endcase
      end else if (scl_fall && st == S_RDATA && bitcnt != 4'd0) begin
        tx <= {tx[6:0], 1'b0};
      end
    end
  end
endmodule

module i2c_regport_chk #(
  parameter int BANK_BITS = 4,
  parameter int PW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_in,
  input logic          sda_oe,
  input logic [PW-1:0] reg_addr,
  input logic          reg_wr,
  input logic          reg_rd
);
  // R11
  oe_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_in);
  // R11
  rd_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |-> !scl_in);
  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_rd));
  // R6
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> reg_addr[PW-1] == $past(reg_addr[PW-1]));
  // R6
  wrap_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> reg_addr[BANK_BITS-1:0] == $past(reg_addr[BANK_BITS-1:0]) + 1'b1);
endmodule

bind i2c_regport i2c_regport_chk #(.BANK_BITS(BANK_BITS), .PW(PW)) chk_i (
  .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_oe(sda_oe),
  .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd));

// File: tb/i2c_regport_test.sv
`timescale 1ns/1ps
module i2c_regport_test;
  localparam logic [6:0] DEV = 7'h32;
  localparam int Q = 10;

  logic clk = 1'b0, rst_n = 1'b0, m_scl = 1'b1, m_sda = 1'b1;
  logic sda_oe, reg_wr, reg_rd;
  logic [4:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic [7:0] regs [32];
  logic [7:0] model [32];
  logic [4:0] mptr;
  int errors = 0, checks = 0, wr_count = 0, bad_oe = 0, bad_rd = 0;
  logic oe_prev = 1'b0;

  always #2.5 clk = ~clk;
  wire sda_line = ~sda_oe & m_sda;

  i2c_regport #(.DEV_ADDR(DEV)) uut (
    .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_line), .sda_oe(sda_oe),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata));

  function automatic logic [7:0] initv(input int i);
    return 8'((i * 37 + 11) ^ 8'h5a);
  endfunction
  function automatic logic [4:0] bump(input logic [4:0] p);
    return {p[4], p[3:0] + 4'd1};
  endfunction

  assign reg_rdata = regs[reg_addr];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) regs[i] <= initv(i);
    end else begin
      if (reg_wr) begin
        regs[reg_addr] <= reg_wdata;
        wr_count <= wr_count + 1;
      end
      if (sda_oe != oe_prev && m_scl) bad_oe <= bad_oe + 1;
      if (reg_rd && m_scl) bad_rd <= bad_rd + 1;
      oe_prev <= sda_oe;
    end
  end

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask
  task automatic bstart();
    m_sda = 1; tick(Q); m_scl = 1; tick(Q); m_sda = 0; tick(Q); m_scl = 0; tick(Q);
  endtask
  task automatic bstop();
    m_sda = 0; tick(Q); m_scl = 1; tick(Q); m_sda = 1; tick(Q);
  endtask
  task automatic bit_out(input logic b);
    m_sda = b; tick(Q); m_scl = 1; tick(Q); m_scl = 0; tick(Q);
  endtask
  task automatic bit_in(output logic b);
    m_sda = 1; tick(Q); m_scl = 1; tick(Q / 2); b = sda_line; tick(Q / 2); m_scl = 0; tick(Q);
  endtask
  task automatic wbyte(input logic [7:0] d, output logic ack);
    for (int i = 7; i >= 0; i--) bit_out(d[i]);
    bit_in(ack);
  endtask
  task automatic rbyte(output logic [7:0] d, input logic nack);
    for (int i = 7; i >= 0; i--) bit_in(d[i]);
    bit_out(nack);
  endtask

  task automatic check_file(input string r);
    int bad = 0;
    for (int i = 0; i < 32; i++) if (regs[i] !== model[i]) bad++;
    chk(bad == 0, r, bad, 0);
  endtask

  task automatic do_write(input logic [4:0] p, input int n);
    logic a;
    logic [7:0] d;
    bstart();
    wbyte({DEV, 1'b0}, a); chk(a == 0, "R2 write address ack", a, 0);
    wbyte({3'b000, p}, a); chk(a == 0, "R4 pointer byte ack", a, 0);
    mptr = p;
    for (int i = 0; i < n; i++) begin
      d = 8'($urandom);
      wbyte(d, a); chk(a == 0, "R5 data ack", a, 0);
      model[mptr] = d;
      mptr = bump(mptr);
    end
    bstop();
    check_file("R5 register contents");
    chk(reg_addr == mptr, "R6 pointer after burst", reg_addr, mptr);
  endtask

  task automatic do_read(input bit comb, input logic [4:0] p, input int n);
    logic a, b;
    logic [7:0] d;
    bstart();
    if (comb) begin
      wbyte({DEV, 1'b0}, a); chk(a == 0, "R2 write address ack", a, 0);
      wbyte({3'b000, p}, a); chk(a == 0, "R4 pointer byte ack", a, 0);
      mptr = p;
      bstart();
    end
    wbyte({DEV, 1'b1}, a); chk(a == 0, "R2 read address ack", a, 0);
    for (int i = 0; i < n; i++) begin
      rbyte(d, i == n - 1);
      chk(d == model[mptr], comb ? "R7 combined read data" : "R10 current read data", d, model[mptr]);
      mptr = bump(mptr);
    end
    bit_in(b); chk(b == 1, "R9 SDA released after NACK", b, 1);
    bit_in(b); chk(b == 1, "R9 SDA released after NACK", b, 1);
    chk(reg_addr == mptr, "R8 pointer advanced per byte", reg_addr, mptr);
    bstop();
  endtask

  initial begin
    logic a;
    int w0;
    void'($urandom(32'h5eed1234));
    for (int i = 0; i < 32; i++) model[i] = initv(i);
    mptr = 5'h00;
    tick(5);
    rst_n = 1;
    tick(2);
    // R1
    chk(sda_oe == 0, "R1 sda_oe after reset", sda_oe, 0);
    chk(reg_addr == 0, "R1 pointer after reset", reg_addr, 0);
    chk(!reg_wr && !reg_rd, "R1 strobes idle", {reg_wr, reg_rd}, 0);
    tick(Q);
    do_read(0, 5'h00, 2);

    // R6 wrap at both bank ends
    do_write(5'h0D, 5);
    chk(reg_addr == 5'h02, "R6 wrap 0x0F to 0x00", reg_addr, 5'h02);
    do_write(5'h1D, 5);
    chk(reg_addr == 5'h12, "R6 wrap 0x1F to 0x10", reg_addr, 5'h12);
    do_read(1, 5'h0E, 4);
    do_read(1, 5'h1E, 4);
    do_read(0, 5'h00, 3);

    // R4 pointer-only write then R10 current read across 0x1F
    bstart();
    wbyte({DEV, 1'b0}, a); wbyte(8'h1E, a);
    chk(a == 0, "R4 pointer byte ack", a, 0);
    bstop();
    mptr = 5'h1E;
    chk(reg_addr == 5'h1E, "R4 pointer loaded", reg_addr, 5'h1E);
    do_read(0, 5'h00, 4);

    // R9 early NACK on first byte
    do_read(1, 5'h07, 1);
    do_read(0, 5'h00, 1);

    // R3 foreign address
    w0 = wr_count;
    bstart();
    wbyte({DEV ^ 7'h01, 1'b0}, a); chk(a == 1, "R3 no ack for other address", a, 1);
    wbyte(8'h03, a); chk(a == 1, "R3 later byte ignored", a, 1);
    wbyte(8'hA5, a); chk(a == 1, "R3 later byte ignored", a, 1);
    bstop();
    bstart();
    wbyte({DEV ^ 7'h40, 1'b1}, a); chk(a == 1, "R3 no ack for other read", a, 1);
    bstop();
    chk(wr_count == w0, "R3 no register write", wr_count, w0);
    chk(reg_addr == mptr, "R3 pointer kept", reg_addr, mptr);
    check_file("R3 register file untouched");

    // R12 STOP mid-byte
    bstart();
    wbyte({DEV, 1'b0}, a); wbyte(8'h0C, a);
    mptr = 5'h0C;
    w0 = wr_count;
    for (int i = 0; i < 4; i++) bit_out(1'b0);
    bstop();
    chk(wr_count == w0, "R12 partial byte discarded at STOP", wr_count, w0);
    chk(reg_addr == 5'h0C, "R12 pointer kept at STOP", reg_addr, 5'h0C);
    // R12 START mid-byte
    bstart();
    wbyte({DEV, 1'b0}, a);
    for (int i = 0; i < 3; i++) bit_out(1'b1);
    do_read(0, 5'h00, 2);
    chk(wr_count == w0, "R12 partial byte discarded at START", wr_count, w0);

    for (int k = 0; k < 14; k++) begin
      int kind = int'($urandom % 3);
      logic [4:0] p = 5'($urandom);
      int n = 1 + int'($urandom % 12);
      if (kind == 0) do_write(p, n);
      else if (kind == 1) do_read(1, p, n);
      else do_read(0, 5'h00, n);
    end

    chk(bad_oe == 0, "R11 sda_oe moved with SCL high", bad_oe, 0);
    chk(bad_rd == 0, "R11 reg_rd with SCL high", bad_rd, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule